// File: doc/BRIEF.md
# Flash Programming Launch Controller

This block is the control register that sits in front of an on-chip flash model. It holds two kinds of setting. The first is a mapping field that picks the target of data accesses: the main user array or the hardware security byte. The second is a write-enable bit that lets data writes reach the column latches. It also guards the start of a programming operation. The start is accepted only after a two-write unlock pattern is written into the command field in the upper nibble.

A completed unlock raises a one-cycle launch strobe and sets a busy flag at the same clock edge. The busy flag stays high until the external programming-time counter reports done. While busy, the register ignores every write, so the map cannot be changed and a new unlock cannot start until programming finishes. The command field never reads back. Software polls the busy bit through the read data port.

The column-latch storage and the flash array are outside this block. Software may load any number of latch bytes, from one up to a full page, before it writes the unlock pattern.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, reg_rdata is 00h, busy, launch and data_wr_en are 0, and space_hsb is 0 (user space).
- R2: An accepted write loads the map field from reg_wdata[3:2]. The value 01b selects the hardware security byte (space_hsb=1), so writing 04h maps it. Every other value selects user space (space_hsb=0).
- R3: An accepted write loads the write-enable bit from reg_wdata[1], which drives data_wr_en. With the bit at 0, user space is read-only.
- R4: A write with upper nibble 5h, followed by a write with upper nibble Ah as the next write, raises launch in the cycle after the Ah write. Cycles with no write between the two steps do not break the pattern.
- R5: Any other write between the two steps aborts the pattern, so a later Ah write does not launch. An Ah write with no preceding 5h write does not launch either.
- R6: launch is high for exactly one cycle per completed pattern.
- R7: busy rises together with launch and reads back in reg_rdata[0].
- R8: busy falls in the cycle after prog_done is sampled high while busy. prog_done has no effect while not busy.
- R9: While busy, writes are ignored. The map and write-enable are unchanged, and a 5h write made while busy does not arm the pattern.
- R10: reg_rdata[7:4] always reads as zero, including right after a write with a nonzero upper nibble.
- R11: A 5h write made while already armed keeps the pattern armed, so a following Ah write launches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data: {0000, map, write enable, busy} |
| prog_done | input | 1 | Expiry pulse from the programming-time counter |
| launch | output | 1 | One-cycle programming start strobe |
| space_hsb | output | 1 | 1 = hardware security byte mapped, 0 = user space |
| data_wr_en | output | 1 | Data writes steered into the column latches |
| busy | output | 1 | Programming in progress |

## Verification
The bench builds the block with its default parameters: an 8-bit register, a 4-bit command field with step codes 5h and Ah, and a 2-bit map field. With these values the bench can drive both unlock codes, the abort cases and the restart case from ordinary byte writes. It can also reach every map code, including the two reserved codes that fall back to user space. A behavioural model runs beside the design and is compared on every clock. Directed sequences exercise writes and prog_done pulses that arrive while busy, so the lockout and the done handshake are checked at the exact cycle they take effect.

// File: rtl/fpl_pkg.sv
package fpl_pkg;

   // Bit index of the busy status in the readback word
   localparam int unsigned BUSY_BIT = 0;
   // Bit index of the data write enable
   localparam int unsigned WEN_BIT  = 1;
   // Lowest bit of the map field
   localparam int unsigned MAP_LSB  = 2;

   // Unlock state held between the two command writes
   typedef enum logic [0:0] {
      UNL_IDLE  = 1'b0,
      UNL_ARMED = 1'b1
   } unl_state_e;

endpackage

// File: rtl/fpl_unlock_seq.sv
module fpl_unlock_seq #(
   parameter int unsigned CMD_W = 4,
   parameter logic [CMD_W-1:0] STEP1 = 4'h5,
   parameter logic [CMD_W-1:0] STEP2 = 4'hA
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ok,
   input  logic [CMD_W-1:0] cmd,
   output logic             hit,
   output logic             launch
);
   import fpl_pkg::*;

   unl_state_e state_q, state_d;

   always_comb begin
      hit     = 1'b0;
      state_d = state_q;
      if (wr_ok) begin
         if (state_q == UNL_ARMED && cmd == STEP2) begin
            hit     = 1'b1;
            state_d = UNL_IDLE;
         end else if (cmd == STEP1) begin
            state_d = UNL_ARMED;
         end else begin
            state_d = UNL_IDLE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= UNL_IDLE;
         launch  <= 1'b0;
      end else begin
         state_q <= state_d;
         launch  <= hit;
      end
   end

endmodule

// File: rtl/fpl_busy_track.sv
module fpl_busy_track (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic done,
   output logic busy
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
      end else if (busy) begin
         busy <= ~done;
      end else begin
         busy <= start;
      end
   end

endmodule

// File: rtl/fpl_space_map.sv
module fpl_space_map #(
   parameter int unsigned MAP_W = 2,
   parameter logic [MAP_W-1:0] MAP_HSB = 2'b01
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ok,
   input  logic [MAP_W-1:0] map_in,
   input  logic             wen_in,
   output logic [MAP_W-1:0] map_q,
   output logic             wen_q,
   output logic             space_hsb
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         map_q <= '0;
         wen_q <= 1'b0;
      end else if (wr_ok) begin
         map_q <= map_in;
         wen_q <= wen_in;
      end
   end

   assign space_hsb = (map_q == MAP_HSB);

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl #(
   parameter int unsigned REG_W = 8,
   parameter int unsigned CMD_W = 4,
   parameter int unsigned MAP_W = 2,
   parameter logic [CMD_W-1:0] STEP1   = 4'h5,
   parameter logic [CMD_W-1:0] STEP2   = 4'hA,
   parameter logic [MAP_W-1:0] MAP_HSB = 2'b01
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             prog_done,
   output logic             launch,
   output logic             space_hsb,
   output logic             data_wr_en,
   output logic             busy
);
   import fpl_pkg::*;

   localparam int unsigned CMD_LSB = REG_W - CMD_W;
   localparam int unsigned MAP_TOP = MAP_LSB + MAP_W;
   localparam int unsigned GAP_W   = CMD_LSB - MAP_TOP;

   // Elaboration-time parameter checks
   if (STEP1 == STEP2) begin : g_bad_steps
      $error("flash_prog_ctrl: the two unlock codes must differ");
   end
   if (MAP_TOP > CMD_LSB) begin : g_bad_layout
      $error("flash_prog_ctrl: map field overlaps the command field");
   end

   logic             wr_ok;
   logic             hit;
   logic [MAP_W-1:0] map_q;
   logic             unused_wbits;

   assign wr_ok = reg_wr & ~busy;

   fpl_unlock_seq #(
      .CMD_W (CMD_W),
      .STEP1 (STEP1),
      .STEP2 (STEP2)
   ) i_unlock (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_ok  (wr_ok),
      .cmd    (reg_wdata[REG_W-1:CMD_LSB]),
      .hit    (hit),
      .launch (launch)
   );

   fpl_busy_track i_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .start (hit),
      .done  (prog_done),
      .busy  (busy)
   );

   fpl_space_map #(
      .MAP_W   (MAP_W),
      .MAP_HSB (MAP_HSB)
   ) i_map (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ok     (wr_ok),
      .map_in    (reg_wdata[MAP_TOP-1:MAP_LSB]),
      .wen_in    (reg_wdata[WEN_BIT]),
      .map_q     (map_q),
      .wen_q     (data_wr_en),
      .space_hsb (space_hsb)
   );

   // Readback: command field hidden, status and settings below it
   assign reg_rdata[REG_W-1:CMD_LSB]  = '0;
   assign reg_rdata[MAP_TOP-1:MAP_LSB] = map_q;
   assign reg_rdata[WEN_BIT]           = data_wr_en;
   assign reg_rdata[BUSY_BIT]          = busy;

   if (GAP_W > 0) begin : g_gap
      assign reg_rdata[CMD_LSB-1:MAP_TOP] = '0;
      assign unused_wbits = ^{reg_wdata[CMD_LSB-1:MAP_TOP], reg_wdata[BUSY_BIT]};
   end else begin : g_nogap
      assign unused_wbits = reg_wdata[BUSY_BIT];
   end

endmodule

// File: rtl/fpl_checker.sv
module fpl_checker #(
   parameter int unsigned REG_W = 8,
   parameter int unsigned CMD_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic [REG_W-1:0] reg_rdata,
   input logic             prog_done,
   input logic             launch,
   input logic             space_hsb,
   input logic             data_wr_en,
   input logic             busy
);

   AST_LAUNCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> !launch); // R6

   AST_LAUNCH_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> $past(reg_wr)); // R4

   AST_LAUNCH_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> busy); // R7

   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !prog_done) |=> busy); // R8

   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && prog_done) |=> !busy); // R8

   AST_MAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(space_hsb) && $stable(data_wr_en))); // R9

   AST_NO_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !launch); // R9

   AST_CMD_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[REG_W-1:REG_W-CMD_W] == '0); // R10

endmodule

bind flash_prog_ctrl fpl_checker #(
   .REG_W (REG_W),
   .CMD_W (CMD_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_rdata  (reg_rdata),
   .prog_done  (prog_done),
   .launch     (launch),
   .space_hsb  (space_hsb),
   .data_wr_en (data_wr_en),
   .busy       (busy)
);

// File: tb/test_flash_prog_ctrl.sv
module test_flash_prog_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic       prog_done = 1'b0;
   logic [7:0] reg_rdata;
   logic       launch, space_hsb, data_wr_en, busy;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   // Reference state
   bit       m_busy, m_armed, m_wen, m_launch;
   bit [1:0] m_map;

   always #2.5 clk = ~clk;

   flash_prog_ctrl i_flash_prog_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .prog_done(prog_done), .launch(launch),
      .space_hsb(space_hsb), .data_wr_en(data_wr_en), .busy(busy)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_step(input bit wr, input bit [7:0] d, input bit done);
      bit nl = 1'b0;
      if (m_busy) begin
         if (done) m_busy = 1'b0;
      end else if (wr) begin
         m_map = d[3:2];
         m_wen = d[1];
         if (m_armed && d[7:4] == 4'hA) begin
            nl = 1'b1; m_busy = 1'b1; m_armed = 1'b0;
         end else begin
            m_armed = (d[7:4] == 4'h5);
         end
      end
      m_launch = nl;
   endtask

   task automatic compare_all();
      chk("R4 launch", launch, m_launch);
      chk("R7 busy", busy, m_busy);
      chk("R2 space_hsb", space_hsb, (m_map == 2'b01));
      chk("R3 data_wr_en", data_wr_en, m_wen);
      chk("R10 rdata", reg_rdata, {4'h0, m_map, m_wen, m_busy});
   endtask

   task automatic cyc(input bit wr, input bit [7:0] d, input bit done);
      reg_wr = wr; reg_wdata = d; prog_done = done;
      @(posedge clk);
      model_step(wr, d, done);
      @(negedge clk);
      reg_wr = 1'b0; prog_done = 1'b0;
      compare_all();
   endtask

   task automatic wr(input bit [7:0] d);
      cyc(1'b1, d, 1'b0);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b0);
   endtask

   initial begin
      m_busy = 0; m_armed = 0; m_wen = 0; m_launch = 0; m_map = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 rdata", reg_rdata, 8'h00);
      chk("R1 busy", busy, 0);
      chk("R1 launch", launch, 0);
      chk("R1 space_hsb", space_hsb, 0);
      chk("R1 data_wr_en", data_wr_en, 0);

      // R2 mapping codes
      wr(8'h04); chk("R2 hsb mapped", space_hsb, 1);
      wr(8'h0C); chk("R2 reserved 11", space_hsb, 0);
      wr(8'h08); chk("R2 reserved 10", space_hsb, 0);
      wr(8'h00); chk("R2 user", space_hsb, 0);
      // R3 write enable
      wr(8'h02); chk("R3 wen set", data_wr_en, 1);
      wr(8'h00); chk("R3 read only", data_wr_en, 0);

      // R4/R6/R7 launch with gap cycles
      wr(8'h50); idle(2); wr(8'hA4);
      chk("R4 launch after unlock", launch, 1);
      chk("R7 busy with launch", reg_rdata[0], 1);
      idle(1); chk("R6 launch one cycle", launch, 0);
      idle(2);
      // R9 writes ignored while busy
      wr(8'h0A); chk("R9 map frozen", space_hsb, 1);
      wr(8'h50);
      cyc(1'b0, 8'h00, 1'b1); chk("R8 busy cleared", busy, 0);
      wr(8'hA0); chk("R9 no arm while busy", launch, 0);
      // R8 done while idle
      cyc(1'b0, 8'h00, 1'b1); chk("R8 done idle", busy, 0);

      // R5 abort
      wr(8'h50); wr(8'h30); wr(8'hA0); chk("R5 abort", launch, 0);
      wr(8'hA0); chk("R5 lone step2", launch, 0);
      // R11 restart while armed
      wr(8'h50); wr(8'h52); wr(8'hA2); chk("R11 relaunch", launch, 1);
      idle(3); cyc(1'b0, 8'h00, 1'b1); chk("R8 clear 2", busy, 0);
      // R10 command hidden
      wr(8'h5F); chk("R10 cmd zero", reg_rdata[7:4], 0);
      wr(8'hFF); chk("R10 cmd zero FF", reg_rdata[7:4], 0);
      // Done and write in same busy cycle: write ignored
      wr(8'h50); wr(8'hA0); cyc(1'b1, 8'h04, 1'b1);
      chk("R9 write with done ignored", space_hsb, 0);
      idle(2);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(5.0 * 20000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog R4 actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule